// File: doc/BRIEF.md
# Configuration Frame CRC Scrubbing Checker

This block watches the integrity of configuration memory by sweeping through it on a fixed schedule. A free-running period timer asks for a readback sweep. The readback data comes back as a stream of words, and each frame is bounded by a start marker and an end marker. For every frame the block computes a fresh CRC-32. It then compares the result with the golden value for that frame, which is held in a small codebook that the host fills through a write port before scrubbing begins.

When a frame's CRC does not match its codebook entry, the block stores the index of the failing frame, raises a sticky upset flag, and counts the event. It also watches the schedule: if the next sweep falls due while the previous one is still running, it sets an overrun flag and does not restart the sweep. To let the system test its own response to upsets, the host can arm a one-shot injection that inverts one chosen bit of the incoming stream.

Top module: `cfg_crc_scrub`

## Requirements
- R1: `sweep_start` is a single-cycle pulse. With no sweep in progress it fires once every `PERIOD_CYC` clock cycles. In the same edge it raises `sweep_busy`. The default `PERIOD_CYC` is 180 ms at 50 MHz, which is 9,000,000 cycles.
- R2: `sweep_busy` falls at the clock edge that accepts the end-marked word of frame index `DEPTH-1`. For any earlier frame it stays high.
- R3: If the period timer expires while `sweep_busy` is high, `scrub_overrun` is set and no `sweep_start` pulse is produced. The flag stays set until `err_clr` is asserted.
- R4: Each frame's CRC uses polynomial 0x04C11DB7. Bits are taken most significant first within each word. The register is seeded with all ones at the start-marked word, and no final inversion is applied. The value never depends on earlier frames.
- R5: The frame index starts at 0 after reset. It advances on every accepted end-marked word and wraps from `DEPTH-1` to 0. Each frame is compared with the codebook entry whose write address equals its index.
- R6: On a mismatch, the clock edge that accepts the end-marked word does three things: it sets `upset_flag`, loads the frame index into `upset_frame`, and increments `upset_count`. A matching frame changes none of these.
- R7: `upset_count` saturates at 2^`ERR_W`-1 and never decreases.
- R8: `err_clr` clears `upset_flag` and `scrub_overrun` at the next edge and leaves `upset_count` unchanged. A mismatch in the same cycle as `err_clr` wins, so the flag stays set.
- R9: A one-cycle pulse on `inj_req` inverts bit `inj_bit` of exactly one word: the first valid word accepted in or after the request cycle. Later words pass through unchanged.
- R10: During and after reset, all flags, `upset_count`, `upset_frame` and `sweep_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cb_wr_en | input | 1 | Host codebook write strobe |
| cb_wr_addr | input | IDX_W | Codebook entry (frame index) to write |
| cb_wr_data | input | 32 | Golden CRC for that frame |
| rb_valid | input | 1 | Readback word valid |
| rb_sof | input | 1 | Word is the first of a frame |
| rb_eof | input | 1 | Word is the last of a frame |
| rb_data | input | WORD_W | Readback word |
| inj_req | input | 1 | Arm a one-shot bit inversion |
| inj_bit | input | BIT_W | Bit position to invert |
| err_clr | input | 1 | Clear upset and overrun flags |
| sweep_start | output | 1 | Request a readback sweep (pulse) |
| sweep_busy | output | 1 | Sweep in progress |
| scrub_overrun | output | 1 | Sticky: period expired during a sweep |
| upset_flag | output | 1 | Sticky: a frame CRC mismatched |
| upset_frame | output | IDX_W | Index of the last mismatching frame |
| upset_count | output | ERR_W | Saturating mismatch count |

## Verification
All results are registered. The upset flag, frame index and count, and the fall of `sweep_busy`, appear one edge after the end-marked word is accepted. The bench drives each word at a falling edge and checks at the very next falling edge, so it samples exactly the state after that edge. The spacing between `sweep_start` pulses is measured in clock cycles and must equal the period exactly. Overrun is checked after waiting one full period longer than the sweep takes. Expected CRCs come from a bit-serial reference in the bench, computed over varied frame lengths.

// File: rtl/scrub_pkg.sv
// Shared constants and the one-bit CRC-32 step used by the scrubbing checker.
// Assumes MSB-first, non-reflected CRC-32 over arbitrary word widths.
package scrub_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    // Advance the CRC register by one input bit.
    function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic d);
        return {c[30:0], 1'b0} ^ ({32{c[31] ^ d}} & CRC_POLY);
    endfunction

endpackage

// File: rtl/scrub_sched.sv
// Scrub scheduler: free-running period counter that launches sweeps,
// tracks the sweep in progress and flags overruns.
// Assumes PERIOD_CYC >= 2 and that sweep_done is a single-cycle pulse.
module scrub_sched #(
    parameter int PERIOD_CYC = 9_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sweep_done,
    input  logic ovr_clr,
    output logic sweep_start,
    output logic sweep_busy,
    output logic overrun
);
    localparam int CNT_W = $clog2(PERIOD_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = (cnt_q == CNT_LAST);

    // Period counter: wraps every PERIOD_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // Sweep launch pulse and busy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_start <= 1'b0;
            sweep_busy  <= 1'b0;
        end else begin
            sweep_start <= tick & ~sweep_busy;
            if (tick && !sweep_busy) sweep_busy <= 1'b1;
            else if (sweep_done)     sweep_busy <= 1'b0;
        end
    end

    // Sticky overrun: a due sweep found the previous one still running.
    always_ff @(posedge clk) begin
        if (!rst_n)                 overrun <= 1'b0;
        else if (tick && sweep_busy) overrun <= 1'b1;
        else if (ovr_clr)           overrun <= 1'b0;
    end

    p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_start |=> !sweep_start);
    p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_busy) |-> sweep_start);
    p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> $past(ovr_clr));

endmodule

// File: rtl/scrub_frame_crc.sv
// Per-frame CRC engine with one-shot upset injection on the input word.
// Assumes the start-marked word is the first word of each frame; the CRC
// register is reseeded there, so no state carries across frames.
module scrub_frame_crc #(
    parameter int WORD_W = 32,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [WORD_W-1:0] in_data,
    input  logic              inj_req,
    input  logic [BIT_W-1:0]  inj_bit,
    output logic              frame_end,
    output logic [31:0]       crc_final
);
    import scrub_pkg::*;

    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    logic [31:0]       crc_q;
    logic              inj_armed;
    logic              inj_pend;
    logic [WORD_W-1:0] word_used;

    assign inj_pend  = inj_armed | inj_req;
    assign word_used = (in_valid && inj_pend) ? (in_data ^ (ONE << inj_bit)) : in_data;
    assign frame_end = in_valid & in_eof;

    // Fold the (possibly corrupted) word into the running CRC, MSB first.
    always_comb begin
        logic [31:0] c;
        c = in_sof ? CRC_SEED : crc_q;
        for (int i = WORD_W - 1; i >= 0; i--) c = crc_bit(c, word_used[i]);
        crc_final = c;
    end

    // Hold the running CRC and the pending injection request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q     <= CRC_SEED;
            inj_armed <= 1'b0;
        end else begin
            if (in_valid) crc_q <= crc_final;
            inj_armed <= inj_pend & ~in_valid;
        end
    end

    p_inj_spent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_pend && in_valid) |=> !inj_armed);

endmodule

// File: rtl/scrub_codebook.sv
// Golden CRC codebook: host write port, asynchronous read by frame index.
// Assumes the host loads it before scrubbing; contents are not reset.
module scrub_codebook #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [31:0]      rd_data
);
    logic [31:0] mem [DEPTH];

    // Host write of one golden entry.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cfg_crc_scrub.sv
// Configuration frame CRC scrubbing checker (top).
// Tracks the frame index, compares each frame CRC with its codebook entry
// and keeps the upset flag, failing index and saturating count.
// Assumes DEPTH >= 2 and that frames arrive in index order.
module cfg_crc_scrub #(
    parameter int WORD_W     = 32,
    parameter int DEPTH      = 64,
    parameter int PERIOD_CYC = 9_000_000,
    parameter int ERR_W      = 16,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int BIT_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cb_wr_en,
    input  logic [IDX_W-1:0]  cb_wr_addr,
    input  logic [31:0]       cb_wr_data,
    input  logic              rb_valid,
    input  logic              rb_sof,
    input  logic              rb_eof,
    input  logic [WORD_W-1:0] rb_data,
    input  logic              inj_req,
    input  logic [BIT_W-1:0]  inj_bit,
    input  logic              err_clr,
    output logic              sweep_start,
    output logic              sweep_busy,
    output logic              scrub_overrun,
    output logic              upset_flag,
    output logic [IDX_W-1:0]  upset_frame,
    output logic [ERR_W-1:0]  upset_count
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
    localparam logic [ERR_W-1:0] CNT_MAX  = '1;

    logic [IDX_W-1:0] frame_idx;
    logic             frame_end;
    logic [31:0]      crc_val;
    logic [31:0]      golden;
    logic             mismatch;
    logic             sweep_done;

    scrub_frame_crc #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_crc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rb_valid), .in_sof(rb_sof), .in_eof(rb_eof), .in_data(rb_data),
        .inj_req(inj_req), .inj_bit(inj_bit),
        .frame_end(frame_end), .crc_final(crc_val)
    );

    scrub_codebook #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_cb (
        .clk(clk), .wr_en(cb_wr_en), .wr_addr(cb_wr_addr), .wr_data(cb_wr_data),
        .rd_addr(frame_idx), .rd_data(golden)
    );

    assign sweep_done = frame_end && (frame_idx == IDX_LAST);
    assign mismatch   = frame_end && (crc_val != golden);

    scrub_sched #(.PERIOD_CYC(PERIOD_CYC)) u_sched (
        .clk(clk), .rst_n(rst_n), .sweep_done(sweep_done), .ovr_clr(err_clr),
        .sweep_start(sweep_start), .sweep_busy(sweep_busy), .overrun(scrub_overrun)
    );

    // Frame index: advances per frame end, wraps after the last codebook entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          frame_idx <= '0;
        else if (sweep_done) frame_idx <= '0;
        else if (frame_end)  frame_idx <= frame_idx + 1'b1;
    end

    // Upset record: sticky flag (mismatch beats clear), failing index, count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upset_flag  <= 1'b0;
            upset_frame <= '0;
            upset_count <= '0;
        end else begin
            if (mismatch)     upset_flag <= 1'b1;
            else if (err_clr) upset_flag <= 1'b0;
            if (mismatch) begin
                upset_frame <= frame_idx;
                if (upset_count != CNT_MAX) upset_count <= upset_count + 1'b1;
            end
        end
    end

    p_idx_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_idx == IDX_LAST) |=> frame_idx == '0);
    p_count_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> upset_count >= $past(upset_count));
    p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upset_count == CNT_MAX |=> upset_count == CNT_MAX);
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upset_flag) |-> $past(err_clr));
    p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_done && sweep_busy) |=> !sweep_busy || sweep_start);

endmodule

// File: tb/tb_cfg_crc_scrub.sv
module tb_cfg_crc_scrub;
    localparam int W  = 32;
    localparam int D  = 4;
    localparam int P  = 200;
    localparam int EW = 4;
    localparam logic [31:0] POLY = 32'h04C11DB7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cb_wr_en = 1'b0;
    logic [1:0] cb_wr_addr = '0;
    logic [31:0] cb_wr_data = '0;
    logic rb_valid = 1'b0, rb_sof = 1'b0, rb_eof = 1'b0;
    logic [W-1:0] rb_data = '0;
    logic inj_req = 1'b0;
    logic [4:0] inj_bit = '0;
    logic err_clr = 1'b0;
    logic sweep_start, sweep_busy, scrub_overrun, upset_flag;
    logic [1:0] upset_frame;
    logic [EW-1:0] upset_count;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int t_start = 0;

    cfg_crc_scrub #(.WORD_W(W), .DEPTH(D), .PERIOD_CYC(P), .ERR_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .cb_wr_en(cb_wr_en), .cb_wr_addr(cb_wr_addr),
        .cb_wr_data(cb_wr_data), .rb_valid(rb_valid), .rb_sof(rb_sof), .rb_eof(rb_eof),
        .rb_data(rb_data), .inj_req(inj_req), .inj_bit(inj_bit), .err_clr(err_clr),
        .sweep_start(sweep_start), .sweep_busy(sweep_busy), .scrub_overrun(scrub_overrun),
        .upset_flag(upset_flag), .upset_frame(upset_frame), .upset_count(upset_count)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int flen(int f);
        return f + 1;
    endfunction

    function automatic logic [31:0] pat(int f, int w);
        return 32'h9E3779B9 * (f * 8 + w + 1) ^ 32'h5A00C300;
    endfunction

    // Bit-serial reference CRC of frame f, optionally with one bit inverted.
    function automatic logic [31:0] ref_crc(int f, int inj_w, int inj_b);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int w = 0; w < flen(f); w++) begin
            logic [31:0] d = pat(f, w);
            if (w == inj_w) d[inj_b] = ~d[inj_b];
            for (int b = 31; b >= 0; b--) begin
                logic fb = c[31] ^ d[b];
                c = c << 1;
                if (fb) c = c ^ POLY;
            end
        end
        return c;
    endfunction

    task automatic cb_write(int a, logic [31:0] v);
        @(negedge clk);
        cb_wr_en = 1'b1; cb_wr_addr = a[1:0]; cb_wr_data = v;
        @(negedge clk);
        cb_wr_en = 1'b0;
    endtask

    // Send frame f; inject at word inj_w (-1: none); raise err_clr with the end word.
    task automatic send_frame(int f, int inj_w, int inj_b, bit clr_at_end);
        for (int w = 0; w < flen(f); w++) begin
            @(negedge clk);
            rb_valid = 1'b1; rb_sof = (w == 0); rb_eof = (w == flen(f) - 1);
            rb_data = pat(f, w);
            inj_req = (w == inj_w); inj_bit = inj_b[4:0];
            err_clr = clr_at_end && (w == flen(f) - 1);
        end
        @(negedge clk);
        rb_valid = 1'b0; rb_sof = 1'b0; rb_eof = 1'b0; inj_req = 1'b0; err_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (!sweep_start) @(negedge clk);
        t_start = cyc;
    endtask

    task automatic run();
        int starts;
        int t_prev;
        // R10: reset state
        repeat (4) @(negedge clk);
        chk("R10 flag", upset_flag, 0);
        chk("R10 count", upset_count, 0);
        chk("R10 overrun", scrub_overrun, 0);
        chk("R10 start", sweep_start, 0);
        chk("R10 busy", sweep_busy, 0);
        rst_n = 1'b1;
        for (int f = 0; f < D; f++) cb_write(f, ref_crc(f, -1, 0));

        // Sweep A: clean frames, busy drops only after the last frame (R2, R4, R5)
        wait_start();
        chk("R1 busy with start", sweep_busy, 1);
        t_prev = t_start;
        @(negedge clk);
        chk("R1 start one cycle", sweep_start, 0);
        for (int f = 0; f < D; f++) begin
            send_frame(f, -1, 0, 0);
            chk("R2 busy per frame", sweep_busy, (f == D - 1) ? 0 : 1);
        end
        chk("R4 clean sweep flag", upset_flag, 0);
        chk("R6 clean sweep count", upset_count, 0);

        // R1: period between launches
        wait_start();
        chk("R1 period", t_start - t_prev, P);

        // Sweep B: inject MSB of word 1 of frame 2 (R9, R6)
        send_frame(0, -1, 0, 0);
        send_frame(1, -1, 0, 0);
        send_frame(2, 1, 31, 0);
        chk("R6 flag on inject", upset_flag, 1);
        chk("R6 frame on inject", upset_frame, 2);
        chk("R6 count on inject", upset_count, 1);
        send_frame(3, -1, 0, 0);
        chk("R9 one shot", upset_count, 1);
        chk("R6 frame held", upset_frame, 2);
        pulse_clr();
        chk("R8 clear flag", upset_flag, 0);
        chk("R8 count kept", upset_count, 1);

        // Sweep C: wrong golden entry for frame 1, clear coincident (R5, R8)
        cb_write(1, ref_crc(1, -1, 0) ^ 32'h1);
        wait_start();
        send_frame(0, -1, 0, 0);
        chk("R5 frame 0 ok", upset_count, 1);
        send_frame(1, -1, 0, 1);
        chk("R8 mismatch beats clear", upset_flag, 1);
        chk("R5 failing index", upset_frame, 1);
        chk("R7 count step", upset_count, 2);
        send_frame(2, -1, 0, 0);
        send_frame(3, -1, 0, 0);
        chk("R5 later frames ok", upset_count, 2);
        cb_write(1, ref_crc(1, -1, 0));

        // Sweep D: no data, period expires while busy (R3)
        wait_start();
        starts = 0;
        repeat (P + 10) begin
            @(negedge clk);
            if (sweep_start) starts++;
        end
        chk("R3 no relaunch", starts, 0);
        chk("R3 overrun set", scrub_overrun, 1);
        chk("R3 still busy", sweep_busy, 1);
        for (int f = 0; f < D; f++) send_frame(f, -1, 0, 0);
        chk("R2 busy after late sweep", sweep_busy, 0);
        chk("R3 overrun sticky", scrub_overrun, 1);
        pulse_clr();
        chk("R3 overrun cleared", scrub_overrun, 0);
        chk("R8 flag cleared", upset_flag, 0);

        // R7: saturation with all golden entries wrong
        for (int f = 0; f < D; f++) cb_write(f, ~ref_crc(f, -1, 0));
        for (int g = 0; g < 5; g++) begin
            for (int f = 0; f < D; f++) send_frame(f, -1, 0, 0);
            chk("R7 count", upset_count, (2 + 4 * (g + 1) > 15) ? 15 : 2 + 4 * (g + 1));
        end
        chk("R6 last index", upset_frame, 3);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule